// File: doc/BRIEF.md
# Four-Mode Programmable Delay Timer

This block is a synchronous delay timer. A binary delay word sets the length of a delay as a count of time-base ticks. The tick is a one-cycle enable pulse from an external prescaler. A trigger input starts or restarts the delay. One output follows the trigger under one of four modes: one-shot, delayed operate, delayed release and dual delay.

The trigger is asynchronous. It passes through a synchronizer chain, and both edges are detected on the synchronized level. The mode bits apply only while no delay is running, so a delay in progress always ends under the mode that started it. A synchronous reset aborts any delay. It also puts the output in the idle level of the selected mode.

Top module: `pdt_timer`

## Requirements
- R1: During and after reset the timer is idle. The output is 1 in mode 00 (one-shot) and mode 01 (delayed operate), 0 in mode 10 (delayed release), and the inverse of the trigger in mode 11 (dual delay). Mode is {mode_a, mode_b}.
- R2: In one-shot mode a rising trigger edge drives the output to 0. This happens on the third rising clock edge after the trigger changes, which counts the two synchronizer stages and the output register. The same edge starts the delay, and the output returns to 1 when the delay expires.
- R3: In one-shot mode a rising edge during a running delay restarts the delay from the full delay word. A falling edge has no effect.
- R4: In delayed operate mode a rising edge starts the delay, and the output goes to 0 on expiry. A falling edge drives the output to 1 with the same three-clock latency and cancels any running delay.
- R5: In delayed release mode a falling edge starts the delay, and the output goes to 1 on expiry. A rising edge drives the output to 0 with three-clock latency and cancels any running delay.
- R6: In dual delay mode either edge starts or restarts the delay. On expiry the output takes the inverse of the synchronized trigger level.
- R7: The delay word W is loaded when a delay starts. With the tick held at 1, the expiry action appears max(W,1) clocks after the start action would appear. A word of 0 therefore expires one clock after the start.
- R8: The count drops by one only in cycles where the tick is 1. Expiry happens on the tick that takes the count from 1 to 0. With the tick held at 0, a running delay never expires.
- R9: Reset aborts a running delay, and no expiry action follows.
- R10: The mode inputs are sampled only while the timer is idle. A mode change during a delay does not alter that delay's expiry action, and it applies to trigger edges only after the delay ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset and abort, active high |
| tick | input | 1 | Time-base enable, one pulse per delay unit |
| trig | input | 1 | Asynchronous trigger |
| mode_a | input | 1 | Mode select, upper bit |
| mode_b | input | 1 | Mode select, lower bit |
| delay_word | input | DW | Delay length in ticks, bit 0 least significant |
| dout | output | 1 | Delay output |

## Verification
The bench builds the timer with a 4-bit delay word. This keeps a full sweep over all four modes and all sixteen delay values short. At that width the zero word, the one word and the largest word are all reached in every mode. The expiry cycle for each case comes from the formula 3 + max(W,1). Directed cases with gated ticks, retriggers, cancels, mid-delay resets and mid-delay mode changes cover the ordering rules that a sweep with a constant tick does not reach.

// File: rtl/pdt_timer.sv
module pdt_timer #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          trig,
  input  logic          mode_a,
  input  logic          mode_b,
  input  logic [DW-1:0] delay_word,
  output logic          dout
);

  localparam logic [1:0] M_OS = 2'b00;
  localparam logic [1:0] M_DO = 2'b01;
  localparam logic [1:0] M_DR = 2'b10;
  localparam logic [1:0] M_DD = 2'b11;

  logic [SYNC-1:0] sync_q;
  logic            trig_s, trig_d;
  logic            running;
  logic [DW-1:0]   cnt;
  logic [1:0]      mode_q, mode_in, mode_cur;
  logic            rise, fall, expire;
  logic            start, halt, load_out, out_nxt;

  assign trig_s   = sync_q[SYNC-1];
  assign rise     = trig_s & ~trig_d;
  assign fall     = ~trig_s & trig_d;
  assign mode_in  = {mode_a, mode_b};
  assign mode_cur = running ? mode_q : mode_in;
  assign expire   = running & ((cnt == '0) | (tick & (cnt == DW'(1))));

  always_comb begin
    start    = 1'b0;
    halt     = 1'b0;
    load_out = 1'b0;
    out_nxt  = dout;
    unique case (mode_cur)
      M_OS: begin
        if (rise) begin
          start = 1'b1; load_out = 1'b1; out_nxt = 1'b0;
        end else if (expire) begin
          halt = 1'b1; load_out = 1'b1; out_nxt = 1'b1;
        end
      end
      M_DO: begin
        if (rise) begin
          start = 1'b1;
        end else if (fall) begin
          halt = 1'b1; load_out = 1'b1; out_nxt = 1'b1;
        end else if (expire) begin
          halt = 1'b1; load_out = 1'b1; out_nxt = 1'b0;
        end
      end
      M_DR: begin
        if (fall) begin
          start = 1'b1;
        end else if (rise) begin
          halt = 1'b1; load_out = 1'b1; out_nxt = 1'b0;
        end else if (expire) begin
          halt = 1'b1; load_out = 1'b1; out_nxt = 1'b1;
        end
      end
      default: begin
        if (rise | fall) begin
          start = 1'b1;
        end else if (expire) begin
          halt = 1'b1; load_out = 1'b1; out_nxt = ~trig_s;
        end
      end
    endcase
  end

  generate
    if (SYNC > 1) begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= {SYNC{trig}};
        else     sync_q <= {sync_q[SYNC-2:0], trig};
      end
    end else begin : g_sync_one
      always_ff @(posedge clk) sync_q <= trig;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_d  <= trig;
      running <= 1'b0;
      cnt     <= '0;
      mode_q  <= mode_in;
      dout    <= (mode_in == M_DR) ? 1'b0 : (mode_in == M_DD) ? ~trig : 1'b1;
    end else begin
      trig_d <= trig_s;
      if (!running) mode_q <= mode_in;
      if (load_out) dout <= out_nxt;
      if (start) begin
        running <= 1'b1;
        cnt     <= delay_word;
      end else if (halt) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (running && tick && cnt != '0) begin
        cnt <= cnt - DW'(1);
      end
    end
  end

endmodule

module pdt_timer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          mode_a,
  input logic          mode_b,
  input logic          dout,
  input logic          running,
  input logic [DW-1:0] cnt,
  input logic [1:0]    mode_q,
  input logic          rise,
  input logic          fall,
  input logic          trig_s
);
  logic [1:0] m_eff;
  logic       exp_now;
  assign m_eff   = running ? mode_q : {mode_a, mode_b};
  assign exp_now = running & ((cnt == '0) | (tick & (cnt == DW'(1))));

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !running); // R9
  AST_OS_RISE_LOW: assert property (@(posedge clk) disable iff (rst)
    (m_eff == 2'b00 && rise) |=> !dout); // R2
  AST_DO_FALL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (m_eff == 2'b01 && fall) |=> (dout && !running)); // R4
  AST_DR_RISE_LOW: assert property (@(posedge clk) disable iff (rst)
    (m_eff == 2'b10 && rise) |=> (!dout && !running)); // R5
  AST_DD_EXPIRE: assert property (@(posedge clk) disable iff (rst)
    (m_eff == 2'b11 && exp_now && !rise && !fall) |=> (dout == !$past(trig_s))); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (running && !tick && !rise && !fall && !exp_now) |=> ($stable(cnt) && running)); // R8
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (running && !rise && !fall && !exp_now) |=> $stable(mode_q)); // R10
endmodule

bind pdt_timer pdt_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .mode_a(mode_a), .mode_b(mode_b),
  .dout(dout), .running(running), .cnt(cnt), .mode_q(mode_q),
  .rise(rise), .fall(fall), .trig_s(trig_s)
);

// File: tb/pdt_timer_test.sv
module pdt_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic trig = 1'b0;
  logic mode_a = 1'b0, mode_b = 1'b0;
  logic [DW-1:0] delay_word = '0;
  logic dout;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdt_timer #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .tick(tick), .trig(trig),
    .mode_a(mode_a), .mode_b(mode_b), .delay_word(delay_word), .dout(dout)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    n_run++;
    if (dout !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: dout=%b expected %b", req, $time, dout, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic t, input logic [DW-1:0] w);
    rst = 1'b1; {mode_a, mode_b} = m; trig = t; delay_word = w; tick = 1'b1;
    cyc(2);
    rst = 1'b0;
    chk("R1 reset level", (m == 2'b10) ? 1'b0 : (m == 2'b11) ? ~t : 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(1);
    for (int w = 0; w < (1 << DW); w++) begin
      int d;
      d = (w == 0) ? 1 : w;
      // R2 / R7 / R3 one-shot
      do_reset(2'b00, 1'b0, DW'(w));
      trig = 1'b1; cyc(2); chk("R2 before latency", 1'b1);
      cyc(1); chk("R2 immediate low", 1'b0);
      cyc(d - 1); chk("R7 os before expiry", 1'b0);
      cyc(1); chk("R7 os expiry high", 1'b1);
      trig = 1'b0; cyc(23); chk("R3 falling ignored", 1'b1);
      // R4 delayed operate
      do_reset(2'b01, 1'b0, DW'(w));
      trig = 1'b1; cyc(2 + d); chk("R7 do before expiry", 1'b1);
      cyc(1); chk("R4 do expiry low", 1'b0);
      trig = 1'b0; cyc(2); chk("R4 do before latency", 1'b0);
      cyc(1); chk("R4 do fall high", 1'b1);
      // R5 delayed release
      do_reset(2'b10, 1'b1, DW'(w));
      trig = 1'b0; cyc(2 + d); chk("R7 dr before expiry", 1'b0);
      cyc(1); chk("R5 dr expiry high", 1'b1);
      trig = 1'b1; cyc(2); chk("R5 dr before latency", 1'b1);
      cyc(1); chk("R5 dr rise low", 1'b0);
      // R6 dual delay
      do_reset(2'b11, 1'b0, DW'(w));
      trig = 1'b1; cyc(2 + d); chk("R7 dd before expiry", 1'b1);
      cyc(1); chk("R6 dd expiry low", 1'b0);
      trig = 1'b0; cyc(2 + d); chk("R7 dd before expiry", 1'b0);
      cyc(1); chk("R6 dd expiry high", 1'b1);
    end

    // R3 one-shot retrigger
    do_reset(2'b00, 1'b0, DW'(8));
    trig = 1'b1; cyc(4); trig = 1'b0; cyc(2); trig = 1'b1;
    cyc(10); chk("R3 retrigger extends", 1'b0);
    cyc(1); chk("R3 retrigger expiry", 1'b1);

    // R6 dual retrigger
    do_reset(2'b11, 1'b0, DW'(8));
    trig = 1'b1; cyc(4); trig = 1'b0; cyc(2); trig = 1'b1;
    cyc(10); chk("R6 dd retrigger extends", 1'b1);
    cyc(1); chk("R6 dd retrigger expiry", 1'b0);

    // R4 cancel by falling edge
    do_reset(2'b01, 1'b0, DW'(10));
    trig = 1'b1; cyc(4); trig = 1'b0; cyc(30); chk("R4 fall cancels", 1'b1);

    // R5 cancel by rising edge
    do_reset(2'b10, 1'b1, DW'(10));
    trig = 1'b0; cyc(4); trig = 1'b1; cyc(30); chk("R5 rise cancels", 1'b0);

    // R9 reset abort
    do_reset(2'b01, 1'b0, DW'(10));
    trig = 1'b1; cyc(5); rst = 1'b1; cyc(1); rst = 1'b0;
    cyc(30); chk("R9 abort no expiry", 1'b1);

    // R10 mode held during delay
    do_reset(2'b01, 1'b0, DW'(8));
    trig = 1'b1; cyc(5); {mode_a, mode_b} = 2'b00;
    cyc(20); chk("R10 expiry in start mode", 1'b0);
    trig = 1'b0; cyc(20); chk("R10 new mode after idle", 1'b0);

    // R8 tick gating
    do_reset(2'b01, 1'b0, DW'(5));
    tick = 1'b0; trig = 1'b1; cyc(20); chk("R8 no tick no expiry", 1'b1);
    for (int k = 0; k < 4; k++) begin
      tick = 1'b1; cyc(1); tick = 1'b0; cyc(2);
    end
    chk("R8 four ticks not enough", 1'b1);
    tick = 1'b1; cyc(1); tick = 1'b0;
    chk("R8 fifth tick expires", 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule